// File: doc/BRIEF.md
# Flash Protection Command Sequencer

This block sits on the byte-wide write and read strobes of a flash-style device and interprets the command cycles that manage sector protection. A protection mode is opened by a three-write unlock-and-select sequence. Inside the open mode, two-write commands act on the protection bits:

- program or erase-all the per-sector persistent bits,
- set the persistent lock bit,
- set or clear the per-sector dynamic bits.

A two-write exit sequence returns the device to array-read mode.

While a mode is open and no command is half entered, a read strobe returns a protection status bit one cycle later. Any write that does not fit the expected pattern parks the sequencer in an error state. Only the reset command byte, or a hardware reset, leaves that state. The sector that a command or read targets is taken from the top address bits, which split the space into equal sectors.

The state register holds one of eight states:

- `S_IDLE`: array-read mode.
- `S_UNL1`: the first unlock write has been seen.
- `S_UNL2`: the second unlock write has been seen.
- `S_CMD`: a mode is open and waits for a command.
- `S_ARG`: the second write of a program, set or clear command is awaited.
- `S_ERA`: the erase confirm is awaited.
- `S_EXIT`: the exit confirm is awaited.
- `S_ERR`: a wrong write has been seen.

The transitions are:

- `S_IDLE` to `S_UNL1` on AA at AAA.
- `S_UNL1` to `S_UNL2` on 55 at 555.
- `S_UNL2` to `S_CMD` on a valid mode code at AAA.
- `S_CMD` to `S_ARG` on A0.
- `S_CMD` to `S_ERA` on 80, in persistent mode only.
- `S_CMD` to `S_EXIT` on 90.
- `S_ARG` back to `S_CMD` on a valid argument.
- `S_ERA` back to `S_CMD` on 30 at address 0.
- `S_EXIT` to `S_IDLE` on 00.
- Any other write goes to `S_ERR`.
- F0 returns every state to `S_IDLE`.

Top module: `prot_cmd_seq`

## Requirements
- R1: After hardware reset (rst_n low): mode_o is 0, err_o is 0, pers_o, dyn_o and lock_o are all 0, and rd_valid is 0.
- R2: The writes AA at address AAA, then 55 at 555, then a mode code at AAA open a mode, with all values hexadecimal. The code C0 gives mode_o=1 (persistent), 50 gives mode_o=2 (lock) and E0 gives mode_o=3 (dynamic). mode_o shows the new mode after the clock edge of the third write.
- R3: In an open mode with no command pending, 90 to any address followed by 00 to any address sets mode_o to 0 and returns to array-read mode.
- R4: In mode 1, A0 to any address then 00 to an address in sector s sets pers_o[s]. A set bit means protected.
- R5: In mode 1, 80 to any address then 30 to address 0 clears every bit of pers_o.
- R6: In mode 2, A0 then 00 (any addresses) sets lock_o. Only rst_n clears lock_o.
- R7: While lock_o is 1, the program and erase-all commands are still accepted without error, but they leave pers_o unchanged.
- R8: In mode 3, A0 then 00 to a sector address sets dyn_o of that sector. A0 then 01 clears it. dyn_o changes in no other mode.
- R9: Any write that does not match the expected pattern sets err_o and forces mode_o to 0. Such writes include:
  - a wrong address or data byte;
  - a right byte out of order;
  - an unknown mode code;
  - 80 outside mode 1;
  - 01 as the argument outside mode 3.

  err_o stays 1 and further writes are ignored until F0 is written.
- R10: Writing F0 to any address in any state returns to array-read mode (mode_o=0, err_o=0). The protection bits keep their values.
- R11: A read (rd_en=1 with wr_en=0) in an open mode with no command pending sets rd_valid for the next cycle. rd_bit is then 0 if the target is protected and 1 if it is not. The target is pers_o[s] in mode 1, lock_o in mode 2 and dyn_o[s] in mode 3. Any other read leaves rd_valid at 0.
- R12: The sector s of an address is its top SECT_W bits (bus_addr[11:9] at the defaults), giving 2^SECT_W equal sectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_addr | input | ADDR_W | Byte address of the bus cycle |
| bus_wdata | input | 8 | Write data byte |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| rd_en | input | 1 | Read strobe, one cycle per bus read |
| mode_o | output | 2 | Open mode: 0 none, 1 persistent, 2 lock, 3 dynamic |
| err_o | output | 1 | Sequencer is in the error state |
| pers_o | output | NSECT | Persistent protection bits, one per sector |
| dyn_o | output | NSECT | Dynamic protection bits, one per sector |
| lock_o | output | 1 | Persistent lock bit |
| rd_valid | output | 1 | Status bit valid, one cycle after a read |
| rd_bit | output | 1 | Status bit: 0 protected, 1 unprotected |

## Verification
Every write takes effect at the clock edge on which its strobe is sampled:

- state, mode, error and bit outputs are due one edge after the write;
- a status read is answered one edge after the read strobe.

The bench drives strobes at the falling edge for exactly one rising edge. It updates its queue-based model on that same rising edge and compares every output at the following falling edge. Directed checks placed after each task compare against fixed values due at that same falling edge. The status bit is compared only in cycles where the model expects rd_valid.

// File: rtl/prot_pkg.sv
package prot_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_UNL1,
        S_UNL2,
        S_CMD,
        S_ARG,
        S_ERA,
        S_EXIT,
        S_ERR
    } seq_state_t;

    typedef enum logic [1:0] {
        M_NONE = 2'd0,
        M_PERS = 2'd1,
        M_LOCK = 2'd2,
        M_DYN  = 2'd3
    } prot_mode_t;

    typedef struct packed {
        logic pers_set;
        logic pers_wipe;
        logic lock_set;
        logic dyn_set;
        logic dyn_clr;
    } prot_op_t;

    localparam logic [7:0] C_UNL1   = 8'hAA;
    localparam logic [7:0] C_UNL2   = 8'h55;
    localparam logic [7:0] C_PERS   = 8'hC0;
    localparam logic [7:0] C_LOCK   = 8'h50;
    localparam logic [7:0] C_DYN    = 8'hE0;
    localparam logic [7:0] C_PROG   = 8'hA0;
    localparam logic [7:0] C_ERASE  = 8'h80;
    localparam logic [7:0] C_ERCONF = 8'h30;
    localparam logic [7:0] C_EXIT   = 8'h90;
    localparam logic [7:0] C_ZERO   = 8'h00;
    localparam logic [7:0] C_ONE    = 8'h01;
    localparam logic [7:0] C_RESET  = 8'hF0;

endpackage

// File: rtl/prot_sect_map.sv
module prot_sect_map #(
    parameter int ADDR_W = 12,
    parameter int SECT_W = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [SECT_W-1:0] sect
);
    // equal-sized sectors: the top address bits pick the sector
    assign sect = addr[ADDR_W-1 -: SECT_W];
endmodule

// File: rtl/prot_fsm.sv
module prot_fsm
    import prot_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output prot_mode_t        mode,
    output logic              err,
    output logic              cmd_rdy,
    output prot_op_t          op
);
    localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(12'hAAA);
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(12'h555);

    seq_state_t st, st_nx;
    prot_mode_t md, md_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= S_IDLE;
            md <= M_NONE;
        end else begin
            st <= st_nx;
            md <= md_nx;
        end
    end

    // next-state decode
    always_comb begin
        st_nx = st;
        md_nx = md;
        if (wr_en) begin
            if (wdata == C_RESET) begin
                st_nx = S_IDLE;
                md_nx = M_NONE;
            end else begin
                unique case (st)
                    S_IDLE: st_nx = (addr == A_HI && wdata == C_UNL1) ? S_UNL1 : S_ERR;
                    S_UNL1: st_nx = (addr == A_LO && wdata == C_UNL2) ? S_UNL2 : S_ERR;
                    S_UNL2: begin
                        st_nx = S_ERR;
                        if (addr == A_HI) begin
                            if (wdata == C_PERS) begin
                                st_nx = S_CMD;
                                md_nx = M_PERS;
                            end else if (wdata == C_LOCK) begin
                                st_nx = S_CMD;
                                md_nx = M_LOCK;
                            end else if (wdata == C_DYN) begin
                                st_nx = S_CMD;
                                md_nx = M_DYN;
                            end
                        end
                    end
                    S_CMD: begin
                        if (wdata == C_PROG)
                            st_nx = S_ARG;
                        else if (wdata == C_EXIT)
                            st_nx = S_EXIT;
                        else if (wdata == C_ERASE && md == M_PERS)
                            st_nx = S_ERA;
                        else
                            st_nx = S_ERR;
                    end
                    S_ARG: begin
                        if (wdata == C_ZERO)
                            st_nx = S_CMD;
                        else if (wdata == C_ONE && md == M_DYN)
                            st_nx = S_CMD;
                        else
                            st_nx = S_ERR;
                    end
                    S_ERA:  st_nx = (wdata == C_ERCONF && addr == '0) ? S_CMD : S_ERR;
                    S_EXIT: begin
                        st_nx = S_ERR;
                        if (wdata == C_ZERO) begin
                            st_nx = S_IDLE;
                            md_nx = M_NONE;
                        end
                    end
                    S_ERR:  st_nx = S_ERR;
                endcase
                if (st_nx == S_ERR)
                    md_nx = M_NONE;
            end
        end
    end

    // outputs
    always_comb begin
        mode    = md;
        err     = (st == S_ERR);
        cmd_rdy = (st == S_CMD);
        op      = '0;
        if (wr_en && st == S_ARG) begin
            op.pers_set = (md == M_PERS) && (wdata == C_ZERO);
            op.lock_set = (md == M_LOCK) && (wdata == C_ZERO);
            op.dyn_set  = (md == M_DYN)  && (wdata == C_ZERO);
            op.dyn_clr  = (md == M_DYN)  && (wdata == C_ONE);
        end
        if (wr_en && st == S_ERA)
            op.pers_wipe = (wdata == C_ERCONF) && (addr == '0);
    end
endmodule

// File: rtl/prot_bits.sv
module prot_bits
    import prot_pkg::*;
#(
    parameter int SECT_W = 3,
    localparam int NSECT = 1 << SECT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  prot_op_t          op,
    input  logic [SECT_W-1:0] sect,
    input  prot_mode_t        mode,
    input  logic              rd_req,
    output logic [NSECT-1:0]  pers,
    output logic [NSECT-1:0]  dyn,
    output logic              lock,
    output logic              rd_valid,
    output logic              rd_bit
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lock <= 1'b0;
        else if (op.lock_set)
            lock <= 1'b1;
    end

    for (genvar i = 0; i < NSECT; i++) begin : g_sect
        logic hit;
        assign hit = (sect == SECT_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                pers[i] <= 1'b0;
            else if (!lock && op.pers_wipe)
                pers[i] <= 1'b0;
            else if (!lock && op.pers_set && hit)
                pers[i] <= 1'b1;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                dyn[i] <= 1'b0;
            else if (op.dyn_set && hit)
                dyn[i] <= 1'b1;
            else if (op.dyn_clr && hit)
                dyn[i] <= 1'b0;
        end
    end

    logic prot_sel;
    always_comb begin
        unique case (mode)
            M_PERS:  prot_sel = pers[sect];
            M_LOCK:  prot_sel = lock;
            M_DYN:   prot_sel = dyn[sect];
            default: prot_sel = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_bit   <= 1'b0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req)
                rd_bit <= ~prot_sel;
        end
    end
endmodule

// File: rtl/prot_cmd_seq.sv
module prot_cmd_seq
    import prot_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int SECT_W = 3,
    localparam int NSECT = 1 << SECT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [1:0]        mode_o,
    output logic              err_o,
    output logic [NSECT-1:0]  pers_o,
    output logic [NSECT-1:0]  dyn_o,
    output logic              lock_o,
    output logic              rd_valid,
    output logic              rd_bit
);
    prot_mode_t        mode;
    prot_op_t          op;
    logic              cmd_rdy;
    logic [SECT_W-1:0] sect;

    prot_sect_map #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_map (
        .addr (bus_addr),
        .sect (sect)
    );

    prot_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .mode    (mode),
        .err     (err_o),
        .cmd_rdy (cmd_rdy),
        .op      (op)
    );

    prot_bits #(.SECT_W(SECT_W)) u_bits (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .sect     (sect),
        .mode     (mode),
        .rd_req   (rd_en && !wr_en && cmd_rdy),
        .pers     (pers_o),
        .dyn      (dyn_o),
        .lock     (lock_o),
        .rd_valid (rd_valid),
        .rd_bit   (rd_bit)
    );

    assign mode_o = mode;
endmodule

// File: rtl/prot_cmd_seq_chk.sv
module prot_cmd_seq_chk #(
    parameter int ADDR_W = 12,
    parameter int SECT_W = 3,
    localparam int NSECT = 1 << SECT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              wr_en,
    input logic              rd_en,
    input logic [1:0]        mode_o,
    input logic              err_o,
    input logic [NSECT-1:0]  pers_o,
    input logic [NSECT-1:0]  dyn_o,
    input logic              lock_o,
    input logic              rd_valid,
    input logic              rd_bit
);
    assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |=> lock_o);

    assert_locked_pers_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |=> $stable(pers_o));

    assert_dyn_only_in_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != 2'd3) |=> $stable(dyn_o));

    assert_err_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !(wr_en && bus_wdata == 8'hF0)) |=> err_o);

    assert_err_no_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (mode_o == 2'd0));

    assert_reset_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_wdata == 8'hF0) |=> (!err_o && mode_o == 2'd0));

    assert_read_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_en && !wr_en && mode_o != 2'd0 && !err_o));
endmodule

bind prot_cmd_seq prot_cmd_seq_chk #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .mode_o    (mode_o),
    .err_o     (err_o),
    .pers_o    (pers_o),
    .dyn_o     (dyn_o),
    .lock_o    (lock_o),
    .rd_valid  (rd_valid),
    .rd_bit    (rd_bit)
);

// File: tb/sim_prot_cmd_seq.sv
module sim_prot_cmd_seq;
    localparam int PERIOD = 10;
    localparam int ADDR_W = 12;
    localparam int SECT_W = 3;
    localparam int NSECT  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [7:0]        bus_wdata = '0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [1:0]        mode_o;
    logic              err_o;
    logic [NSECT-1:0]  pers_o;
    logic [NSECT-1:0]  dyn_o;
    logic              lock_o;
    logic              rd_valid;
    logic              rd_bit;

    prot_cmd_seq #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .wr_en(wr_en), .rd_en(rd_en), .mode_o(mode_o), .err_o(err_o),
        .pers_o(pers_o), .dyn_o(dyn_o), .lock_o(lock_o),
        .rd_valid(rd_valid), .rd_bit(rd_bit)
    );

    always #(PERIOD/2) clk = ~clk;

    int total = 0;
    int bad = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // behavioural reference: pending writes kept in a queue
    int          m_mode = 0;
    bit          m_err = 1'b0;
    logic [7:0]  m_pers = '0;
    logic [7:0]  m_dyn = '0;
    bit          m_lock = 1'b0;
    bit          m_rv = 1'b0;
    bit          m_rb = 1'b0;
    logic [19:0] q[$];
    logic [7:0]  f;
    bit          wrong;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_err = 0; m_pers = '0; m_dyn = '0; m_lock = 0;
            m_rv = 0; m_rb = 0; q.delete();
        end else begin
            m_rv = 0;
            if (wr_en) begin
                if (bus_wdata == 8'hF0) begin
                    m_mode = 0; m_err = 0; q.delete();
                end else if (!m_err) begin
                    q.push_back({bus_addr, bus_wdata});
                    wrong = 0;
                    if (m_mode == 0) begin
                        if (q.size() == 1) wrong = !(bus_addr == 12'hAAA && bus_wdata == 8'hAA);
                        else if (q.size() == 2) wrong = !(bus_addr == 12'h555 && bus_wdata == 8'h55);
                        else begin
                            if (bus_addr != 12'hAAA) wrong = 1;
                            else if (bus_wdata == 8'hC0) m_mode = 1;
                            else if (bus_wdata == 8'h50) m_mode = 2;
                            else if (bus_wdata == 8'hE0) m_mode = 3;
                            else wrong = 1;
                            q.delete();
                        end
                    end else if (q.size() == 1) begin
                        wrong = !(bus_wdata == 8'hA0 || bus_wdata == 8'h90 ||
                                  (bus_wdata == 8'h80 && m_mode == 1));
                    end else begin
                        f = q[0][7:0];
                        if (f == 8'h90) begin
                            if (bus_wdata == 8'h00) m_mode = 0; else wrong = 1;
                        end else if (f == 8'h80) begin
                            if (bus_wdata == 8'h30 && bus_addr == 0) begin
                                if (!m_lock) m_pers = '0;
                            end else wrong = 1;
                        end else begin
                            if (bus_wdata == 8'h00) begin
                                if (m_mode == 1 && !m_lock) m_pers[bus_addr[11:9]] = 1'b1;
                                if (m_mode == 2) m_lock = 1;
                                if (m_mode == 3) m_dyn[bus_addr[11:9]] = 1'b1;
                            end else if (bus_wdata == 8'h01 && m_mode == 3)
                                m_dyn[bus_addr[11:9]] = 1'b0;
                            else wrong = 1;
                        end
                        q.delete();
                    end
                    if (wrong) begin
                        m_err = 1; m_mode = 0; q.delete();
                    end
                end
            end else if (rd_en && !m_err && m_mode != 0 && q.size() == 0) begin
                m_rv = 1;
                if (m_mode == 1) m_rb = !m_pers[bus_addr[11:9]];
                else if (m_mode == 2) m_rb = !m_lock;
                else m_rb = !m_dyn[bus_addr[11:9]];
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2", 32'(mode_o), 32'(m_mode), "mode");
            chk("R9", 32'(err_o), 32'(m_err), "error flag");
            chk("R4", 32'(pers_o), 32'(m_pers), "persistent bits");
            chk("R8", 32'(dyn_o), 32'(m_dyn), "dynamic bits");
            chk("R6", 32'(lock_o), 32'(m_lock), "lock bit");
            chk("R11", 32'(rd_valid), 32'(m_rv), "read valid");
            if (m_rv) chk("R11", 32'(rd_bit), 32'(m_rb), "status bit");
        end
    end

    task automatic wr(logic [11:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [11:0] a);
        @(negedge clk);
        bus_addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic enter(logic [7:0] code);
        wr(12'hAAA, 8'hAA);
        wr(12'h555, 8'h55);
        wr(12'hAAA, code);
    endtask

    task automatic leave();
        wr(12'h123, 8'h90);
        wr(12'h7FE, 8'h00);
    endtask

    function automatic logic [11:0] sa(int s);
        return {3'(s), 9'h1F3};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", 32'(mode_o), 0, "reset mode");
        chk("R1", 32'(err_o), 0, "reset error");
        chk("R1", 32'({pers_o, dyn_o, lock_o, rd_valid}), 0, "reset bits");

        // persistent mode
        enter(8'hC0);
        chk("R2", 32'(mode_o), 1, "persistent mode code");
        rd(sa(3));
        chk("R11", 32'({rd_valid, rd_bit}), 32'b11, "unprotected read");
        wr(12'h456, 8'hA0); wr(sa(3), 8'h00);
        chk("R12", 32'(pers_o), 32'h08, "sector 3 from top bits");
        wr(12'h000, 8'hA0); wr(sa(5), 8'h00);
        chk("R4", 32'(pers_o), 32'h28, "program sector 5");
        rd(sa(5));
        chk("R11", 32'({rd_valid, rd_bit}), 32'b10, "protected read");
        rd(sa(4));
        wr(12'hFFF, 8'h80); wr(12'h000, 8'h30);
        chk("R5", 32'(pers_o), 0, "erase all");
        wr(12'h000, 8'hA0); wr(sa(7), 8'h00);
        wr(12'h000, 8'hA0); wr(sa(0), 8'h00);
        leave();
        chk("R3", 32'(mode_o), 0, "exit to read mode");
        rd(sa(7));
        chk("R11", 32'(rd_valid), 0, "read outside mode");

        // dynamic mode
        enter(8'hE0);
        chk("R2", 32'(mode_o), 3, "dynamic mode code");
        wr(12'h000, 8'hA0); wr(sa(2), 8'h00);
        wr(12'h000, 8'hA0); wr(sa(6), 8'h00);
        wr(12'h000, 8'hA0); wr(sa(2), 8'h01);
        chk("R8", 32'(dyn_o), 32'h40, "dynamic set and clear");
        rd(sa(6)); rd(sa(2));
        // simultaneous read and write: read ignored
        @(negedge clk);
        bus_addr = sa(6); bus_wdata = 8'hA0; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R11", 32'(rd_valid), 0, "read with write");
        wr(sa(6), 8'h00);
        wr(12'h000, 8'h80);
        chk("R9", 32'({err_o, mode_o}), 32'b100, "erase in dynamic mode");
        wr(12'hAAA, 8'hAA);
        chk("R9", 32'(err_o), 1, "error holds");
        wr(12'h321, 8'hF0);
        chk("R10", 32'({err_o, mode_o, dyn_o}), 32'h040, "reset command keeps bits");

        // lock mode
        enter(8'h50);
        chk("R2", 32'(mode_o), 2, "lock mode code");
        rd(12'h000);
        wr(12'h000, 8'hA0); wr(12'hABC, 8'h00);
        chk("R6", 32'(lock_o), 1, "lock set");
        rd(12'h000);
        leave();
        enter(8'hC0);
        wr(12'h000, 8'hA0); wr(sa(1), 8'h00);
        chk("R7", 32'({err_o, pers_o}), 32'h081, "program ignored when locked");
        wr(12'h000, 8'h80); wr(12'h000, 8'h30);
        chk("R7", 32'({err_o, pers_o}), 32'h081, "erase ignored when locked");
        wr(12'h000, 8'hA0); wr(sa(1), 8'h01);
        chk("R9", 32'(err_o), 1, "clear arg in persistent mode");
        wr(12'h000, 8'hF0);

        // more error paths
        wr(12'hAAA, 8'hAA); wr(12'h554, 8'h55);
        chk("R9", 32'(err_o), 1, "wrong unlock address");
        wr(12'h000, 8'hF0);
        wr(12'hAAA, 8'hAA); wr(12'h555, 8'h55); wr(12'hAAA, 8'h77);
        chk("R9", 32'(err_o), 1, "unknown mode code");
        wr(12'h000, 8'hF0);
        wr(12'h555, 8'h55);
        chk("R9", 32'(err_o), 1, "out of order");
        wr(12'h000, 8'hF0);
        enter(8'hE0);
        wr(12'h000, 8'h90); wr(12'h000, 8'h01);
        chk("R9", 32'(err_o), 1, "bad exit confirm");
        wr(12'h000, 8'hF0);
        enter(8'hC0);
        wr(12'h000, 8'hA0);
        wr(12'h000, 8'hF0);
        chk("R10", 32'({err_o, mode_o}), 0, "reset mid-command");
        enter(8'hC0);
        wr(12'h000, 8'h80); wr(12'h001, 8'h30);
        chk("R9", 32'(err_o), 1, "erase confirm wrong address");

        // hardware reset clears lock
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", 32'({err_o, lock_o, dyn_o, pers_o, mode_o}), 0, "hardware reset");
        chk("R6", 32'(lock_o), 0, "lock cleared by reset");

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule